// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block provides the signalling side of a two-port shared memory. The two highest addresses of the memory act as message slots, one for each port. When a port writes the slot that belongs to the other port, the other port gets an interrupt. When that port reads its own slot, its interrupt is cleared. The block does not store data. It watches the access controls of both ports and keeps one interrupt flag per port.

Each port has three active-low controls and an address: select, read/write (low means write) and output enable. A port starts a write when select is low and read/write is low. A port starts a read when select is low, read/write is high and output enable is low. An access counts as starting in the first clock cycle in which all of its conditions hold, whichever control arrived last. Only that cycle, with the address sampled in it, can set or clear a flag. All inputs are taken as synchronous to `clk`. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `mbx_irq_top`

## Requirements
- R1: When reset is asserted and after it is released, both `l_irq_n` and `r_irq_n` are high (inactive) until a qualifying access occurs.
- R2: A left-port write start at the all-ones address (0xFFF for 12 address bits) drives `r_irq_n` low. The change appears at the same rising clock edge at which the start is sampled.
- R3: A right-port read start at the all-ones address drives `r_irq_n` high at the edge where the start is sampled.
- R4: A right-port write start at the all-ones-minus-one address (0xFFE for 12 bits) drives `l_irq_n` low at the edge where it is sampled.
- R5: A left-port read start at the all-ones-minus-one address drives `l_irq_n` high at the edge where it is sampled.
- R6: Only the first cycle of an access can act, using the address of that cycle. Holding an access, or changing its address while it is held, has no further effect. Switching between read and write while select stays low starts a new access.
- R7: If a set and a clear of the same flag are sampled at the same edge, the flag ends up set.
- R8: Accesses to any address other than the two slots leave both flags unchanged. A port writing its own slot, or reading the other port's slot, also leaves both flags unchanged.
- R9: A port that has select low and read/write high, but output enable high, is not reading, so it does not clear its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs_n | input | 1 | Left port select, active low |
| l_rw_n | input | 1 | Left port read/write, low = write |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | ADDR_W | Left port address |
| r_cs_n | input | 1 | Right port select, active low |
| r_rw_n | input | 1 | Right port read/write, low = write |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | ADDR_W | Right port address |
| l_irq_n | output | 1 | Left port interrupt, active low, registered |
| r_irq_n | output | 1 | Right port interrupt, active low, registered |

## Verification
The bench builds the block with `ADDR_W` = 4. The two slots are then 0xF and 0xE, and every other address can be swept from both ports and in both directions in a few dozen cycles. The narrow address also makes random traffic hit the slots often. That brings simultaneous set and clear, read/write switching under a held select, and address changes inside a held access within reach of a short run.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // Classify one port's controls into the access in progress this cycle.
  function automatic acc_kind_e classify(input logic cs_n, input logic rw_n,
                                         input logic oe_n);
    acc_kind_e k;
    if (cs_n)       k = ACC_IDLE;
    else if (!rw_n) k = ACC_WRITE;
    else if (!oe_n) k = ACC_READ;
    else            k = ACC_IDLE;
    return k;
  endfunction

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int               ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] OWN_SLOT  = '1,
  parameter logic [ADDR_W-1:0] PEER_SLOT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              set_peer,
  output logic              clr_own
);

  acc_kind_e kind_d;
  acc_kind_e kind_q;
  logic      start;
  logic      hit_own;
  logic      hit_peer;

  // An access begins when the classified kind changes to a non-idle value.
  always_comb begin
    kind_d   = classify(cs_n, rw_n, oe_n);
    start    = (kind_d != ACC_IDLE) && (kind_d != kind_q);
    hit_own  = (addr == OWN_SLOT);
    hit_peer = (addr == PEER_SLOT);
    set_peer = start && (kind_d == ACC_WRITE) && hit_peer;
    clr_own  = start && (kind_d == ACC_READ) && hit_own;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kind_q <= ACC_IDLE;
    else        kind_q <= kind_d;
  end

  AST_SET_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    set_peer |=> !set_peer); // R6
  AST_CLR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_own |=> !clr_own); // R6
  AST_NOT_BOTH_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_peer && clr_own)); // R8

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  logic flag_d;
  logic flag_q;
  logic flag_en;

  always_comb begin
    flag_en = set || clr;
    flag_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign irq_n = ~flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !irq_n); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> irq_n); // R3
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(irq_n)); // R8

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_rw_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_cs_n,
  input  logic              r_rw_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);

  localparam int               NPORT    = 2;
  localparam logic [ADDR_W-1:0] TOP_SLOT = '1;

  logic                    srst_n;
  logic [NPORT-1:0]        cs_n_v;
  logic [NPORT-1:0]        rw_n_v;
  logic [NPORT-1:0]        oe_n_v;
  logic [ADDR_W-1:0]       addr_v [NPORT];
  logic [NPORT-1:0]        set_peer;
  logic [NPORT-1:0]        clr_own;
  logic [NPORT-1:0]        irq_n_v;

  // Index 0 is the left port, index 1 the right port.
  always_comb begin
    cs_n_v    = {r_cs_n, l_cs_n};
    rw_n_v    = {r_rw_n, l_rw_n};
    oe_n_v    = {r_oe_n, l_oe_n};
    addr_v[0] = l_addr;
    addr_v[1] = r_addr;
  end

  mbx_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .srst_n(srst_n)
  );

  // Left owns TOP_SLOT-1, right owns TOP_SLOT.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .OWN_SLOT (ADDR_W'(TOP_SLOT - 1 + p)),
      .PEER_SLOT(ADDR_W'(TOP_SLOT - p))
    ) u_dec (
      .clk     (clk),
      .rst_n   (srst_n),
      .cs_n    (cs_n_v[p]),
      .rw_n    (rw_n_v[p]),
      .oe_n    (oe_n_v[p]),
      .addr    (addr_v[p]),
      .set_peer(set_peer[p]),
      .clr_own (clr_own[p])
    );

    mbx_irq_flag u_flag (
      .clk  (clk),
      .rst_n(srst_n),
      .set  (set_peer[NPORT-1-p]),
      .clr  (clr_own[p]),
      .irq_n(irq_n_v[p])
    );
  end

  assign l_irq_n = irq_n_v[0];
  assign r_irq_n = irq_n_v[1];

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_n) |-> (l_irq_n && r_irq_n)); // R1
  AST_LEFT_WRITE_SETS_RIGHT: assert property (@(posedge clk) disable iff (!srst_n)
    set_peer[0] |=> !r_irq_n); // R2
  AST_RIGHT_WRITE_SETS_LEFT: assert property (@(posedge clk) disable iff (!srst_n)
    set_peer[1] |=> !l_irq_n); // R4
  AST_LEFT_READ_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    (clr_own[0] && !set_peer[1]) |=> l_irq_n); // R5

endmodule

// File: tb/test_mbx_irq_top.sv
module test_mbx_irq_top;

  localparam int AW  = 4;
  localparam int TOP = (1 << AW) - 1;
  localparam int NXT = TOP - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
  logic r_cs_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  int vectors = 0;
  int misses = 0;
  bit checking = 1'b0;
  string cur_req = "R1";

  int mdl_fl = 0, mdl_fr = 0;
  int mdl_kl = 0, mdl_kr = 0;

  always #10 clk = ~clk;

  mbx_irq_top #(.ADDR_W(AW)) i_mbx_irq_top (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .r_cs_n(r_cs_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  // 0 idle, 1 read, 2 write
  function automatic int kind_of(logic cs, logic rw, logic oe);
    if (cs) return 0;
    if (!rw) return 2;
    if (!oe) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl_fl = 0; mdl_fr = 0; mdl_kl = 0; mdl_kr = 0;
    end else begin
      int kl, kr;
      bit sl, cl, sr, cr;
      kl = kind_of(l_cs_n, l_rw_n, l_oe_n);
      kr = kind_of(r_cs_n, r_rw_n, r_oe_n);
      sr = (kl == 2) && (mdl_kl != 2) && (int'(l_addr) == TOP);
      cl = (kl == 1) && (mdl_kl != 1) && (int'(l_addr) == NXT);
      sl = (kr == 2) && (mdl_kr != 2) && (int'(r_addr) == NXT);
      cr = (kr == 1) && (mdl_kr != 1) && (int'(r_addr) == TOP);
      if (sl) mdl_fl = 1; else if (cl) mdl_fl = 0;
      if (sr) mdl_fr = 1; else if (cr) mdl_fr = 0;
      mdl_kl = kl; mdl_kr = kr;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      if (l_irq_n !== (mdl_fl == 0) || r_irq_n !== (mdl_fr == 0)) begin
        misses++;
        $display("FAIL %s model: l_irq_n=%b exp %b r_irq_n=%b exp %b",
                 cur_req, l_irq_n, (mdl_fl == 0), r_irq_n, (mdl_fr == 0));
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic el, logic er);
    vectors++;
    if (l_irq_n !== el || r_irq_n !== er) begin
      misses++;
      $display("FAIL %s: l_irq_n=%b exp %b r_irq_n=%b exp %b",
               tag, l_irq_n, el, r_irq_n, er);
    end
  endtask

  task automatic drv_l(logic cs, logic rw, logic oe, int a);
    l_cs_n = cs; l_rw_n = rw; l_oe_n = oe; l_addr = AW'(a);
  endtask

  task automatic drv_r(logic cs, logic rw, logic oe, int a);
    r_cs_n = cs; r_rw_n = rw; r_oe_n = oe; r_addr = AW'(a);
  endtask

  task automatic idle_all();
    drv_l(1, 1, 1, 0); drv_r(1, 1, 1, 0);
  endtask

  initial begin
    #(20 * 200000);
    misses++;
    $display("FAIL watchdog: run did not finish, actual hung exp done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1", 1, 1);
    rst_n = 1'b1;
    repeat (4) tick();
    checking = 1'b1;
    chk("R1", 1, 1);

    cur_req = "R2";
    drv_l(0, 0, 1, TOP); tick(); chk("R2", 1, 0);
    idle_all(); tick();

    cur_req = "R9";
    drv_r(0, 1, 1, TOP); tick(); chk("R9", 1, 0);
    cur_req = "R3";
    drv_r(0, 1, 0, TOP); tick(); chk("R3", 1, 1);
    cur_req = "R6";
    drv_l(0, 0, 1, TOP); tick(); chk("R2", 1, 0);
    tick(); chk("R6", 1, 0);
    idle_all(); tick();

    cur_req = "R4";
    drv_r(0, 0, 1, NXT); tick(); chk("R4", 0, 0);
    idle_all(); tick();
    cur_req = "R8";
    drv_l(0, 0, 1, NXT); tick(); chk("R8", 0, 0);
    idle_all(); tick();
    drv_r(0, 1, 0, NXT); tick(); chk("R8", 0, 0);
    idle_all(); tick();
    cur_req = "R5";
    drv_l(0, 1, 0, NXT); tick(); chk("R5", 1, 0);
    idle_all(); tick();
    cur_req = "R3";
    drv_r(0, 1, 0, TOP); tick(); chk("R3", 1, 1);
    idle_all(); tick();

    cur_req = "R6";
    drv_l(0, 0, 1, 3); tick(); chk("R6", 1, 1);
    drv_l(0, 0, 1, TOP); tick(); chk("R6", 1, 1);
    drv_l(0, 1, 0, TOP); tick(); chk("R6", 1, 1);
    drv_l(0, 0, 1, TOP); tick(); chk("R6", 1, 0);
    idle_all(); tick();

    cur_req = "R7";
    drv_l(0, 0, 1, TOP); drv_r(0, 1, 0, TOP); tick(); chk("R7", 1, 0);
    idle_all(); tick();
    drv_r(0, 1, 0, TOP); tick(); chk("R3", 1, 1);
    idle_all(); tick();
    drv_l(0, 0, 1, TOP); drv_r(0, 1, 0, TOP); tick(); chk("R7", 1, 0);
    idle_all(); tick();
    drv_r(0, 0, 1, NXT); drv_l(0, 1, 0, NXT); tick(); chk("R7", 0, 0);
    idle_all(); tick();

    cur_req = "R8";
    for (int a = 0; a < NXT; a++) begin
      drv_l(0, 0, 1, a); drv_r(0, 1, 0, a); tick();
      idle_all(); tick();
      drv_l(0, 1, 0, a); drv_r(0, 0, 1, a); tick();
      idle_all(); tick();
    end
    chk("R8", 0, 0);

    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      int al, ar;
      al = ($urandom_range(0, 1) == 1) ? $urandom_range(NXT, TOP) : $urandom_range(0, TOP);
      ar = ($urandom_range(0, 1) == 1) ? $urandom_range(NXT, TOP) : $urandom_range(0, TOP);
      drv_l($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1), al);
      drv_r($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1), ar);
      tick();
    end
    idle_all(); tick();

    checking = 1'b0;
    rst_n = 1'b0; tick(); chk("R1", 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule